// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Bus

This block gathers up to 32 interrupt lines into one interrupt request for a processor. Each line is fixed at build time as edge-triggered or level-triggered. Events are latched into a status register. A per-line enable mask filters the status into a pending view. A vector register names the lowest-numbered pending line, so a handler can loop on it until it reads all-ones.

Software reaches the block through a plain 32-bit register bus. The bus has a word address, a write strobe and a read strobe, and read data is combinational while the read strobe is high. The enable mask can be written whole, or it can be changed atomically through set-bits and clear-bits aliases. Latched events are cleared by writing ones to an acknowledge register.

A small master-control state machine holds two bits: a global enable and a hardware arm. The request output fires only when both are on. The arm bit is sticky until reset. The states are:
- QUIET (00)
- SW_ONLY (01, global enable without arm)
- ARMED_IDLE (10)
- LIVE (11)

A master write moves QUIET or SW_ONLY to any of the four states. It moves ARMED_IDLE or LIVE only between ARMED_IDLE and LIVE.

Top module: `irqc_top`

## Requirements
- R1: After reset, the status, enable and master registers read 0, the vector reads 0xFFFFFFFF, and `irq_req` is low.
- R2: Writing a mask to word 4 (set-enable) ORs that mask into the enable register and leaves every other enable bit unchanged.
- R3: Writing a mask to word 5 (clear-enable) clears those enable bits and leaves every other bit unchanged.
- R4: Writing word 2 replaces the enable register, and reading word 2 returns it.
- R5: Writing ones to word 3 (acknowledge) clears the matching status bits of word 0 and leaves the others. Writing 0xFFFFFFFF clears every bit that no input is setting in that cycle.
- R6: An edge line, whose EDGE_KIND bit is 1, sets its status bit once on a rising edge. While the line stays high after an acknowledge, the bit stays clear.
- R7: A level line, whose EDGE_KIND bit is 0, sets its status bit in every cycle it is high. An acknowledge while it is high leaves the bit set. Once the line has dropped, an acknowledge clears the bit.
- R8: Word 1 (pending) reads status AND enable.
- R9: Word 6 (vector) reads the index of the lowest-numbered pending line, or 0xFFFFFFFF when nothing is pending.
- R10: In word 7 (master), bit 0 is the global enable and bit 1 is the hardware arm. Writing 0x3 reads back 0x3. `irq_req` is high exactly when some pending bit is set and the master register reads 0x3.
- R11: Once the arm bit is set, only reset clears it. A master write then changes bit 0 only.
- R12: A write to word 0 ORs its data into status only while the arm bit is clear. Once the arm bit is set, such a write has no effect.
- R13: Bits at or above NUM_SRC are ignored on write and read as 0 in every register.
- R14: Status capture and the pending and vector views work whatever the value of the master register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Word address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational, 0 when `reg_rd` is low |
| irq_src | input | NUM_SRC | Interrupt lines |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with NUM_SRC = 8 and EDGE_KIND = 0xA5A5A5F0. This makes lines 0 to 3 level-triggered and lines 4 to 7 edge-triggered, and puts stray ones above the line count that must have no effect. With eight lines, all 256 status patterns can be written through the status register before arming, each paired with a derived enable mask. That sweep checks pending and the lowest-index vector for every pattern. Per-line sweeps then cover each set/clear alias bit and the edge and level capture of every line.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        ST_QUIET      = 2'b00,
        ST_SW_ONLY    = 2'b01,
        ST_ARMED_IDLE = 2'b10,
        ST_LIVE       = 2'b11
    } mst_state_e;

    localparam logic [2:0] A_STATUS  = 3'd0;
    localparam logic [2:0] A_PENDING = 3'd1;
    localparam logic [2:0] A_ENABLE  = 3'd2;
    localparam logic [2:0] A_ACK     = 3'd3;
    localparam logic [2:0] A_SETEN   = 3'd4;
    localparam logic [2:0] A_CLREN   = 3'd5;
    localparam logic [2:0] A_VECTOR  = 3'd6;
    localparam logic [2:0] A_MASTER  = 3'd7;

    localparam logic [31:0] NO_VECTOR = 32'hFFFF_FFFF;
endpackage

// File: rtl/irqc_master.sv
module irqc_master
    import irqc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] wdata_i,
    output logic [1:0] bits_o,
    output logic       armed_o
);
    mst_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (wr_i) begin
            unique case (state_q)
                ST_QUIET, ST_SW_ONLY:
                    state_d = mst_state_e'(wdata_i);
                ST_ARMED_IDLE, ST_LIVE:
                    state_d = wdata_i[0] ? ST_LIVE : ST_ARMED_IDLE;
                default: state_d = ST_QUIET;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        bits_o  = 2'b00;
        armed_o = 1'b0;
        unique case (state_q)
            ST_QUIET:      begin bits_o = 2'b00; armed_o = 1'b0; end
            ST_SW_ONLY:    begin bits_o = 2'b01; armed_o = 1'b0; end
            ST_ARMED_IDLE: begin bits_o = 2'b10; armed_o = 1'b1; end
            ST_LIVE:       begin bits_o = 2'b11; armed_o = 1'b1; end
            default:       begin bits_o = 2'b00; armed_o = 1'b0; end
        endcase
    end

    AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o); // R11
endmodule

// File: rtl/irqc_mask.sv
module irqc_mask #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_full_i,
    input  logic               wr_set_i,
    input  logic               wr_clr_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         en_q <= '0;
        else if (wr_full_i) en_q <= wdata_i;
        else if (wr_set_i)  en_q <= en_q | wdata_i;
        else if (wr_clr_i)  en_q <= en_q & ~wdata_i;
    end

    assign en_o = en_q;

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)) &&
                     ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i)))); // R2
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr_i |=> ((en_o & $past(wdata_i)) == '0) &&
                     ((en_o & ~$past(wdata_i)) == ($past(en_o) & ~$past(wdata_i)))); // R3
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_KIND = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               ack_we_i,
    input  logic               sw_we_i,
    input  logic [NUM_SRC-1:0] wdata_i,
    output logic [NUM_SRC-1:0] status_o
);
    logic [NUM_SRC-1:0] prev_q, hw_set, status_q, ack_mask, sw_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= src_i;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (EDGE_KIND[g]) begin : g_edge
            assign hw_set[g] = src_i[g] & ~prev_q[g];
        end else begin : g_level
            assign hw_set[g] = src_i[g];
        end
    end

    assign ack_mask = ack_we_i ? wdata_i : '0;
    assign sw_mask  = sw_we_i  ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~ack_mask) | hw_set | sw_mask;
    end

    assign status_o = status_q;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> (status_o & $past(wdata_i & ~hw_set)) == '0); // R5
endmodule

// File: rtl/irqc_vector.sv
module irqc_vector #(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic [31:0]        vec_o
);
    always_comb begin
        vec_o = irqc_pkg::NO_VECTOR;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (pend_i[k]) vec_o = 32'(k);
        end
    end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int          NUM_SRC   = 32,
    parameter logic [31:0] EDGE_KIND = 32'h0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         reg_addr,
    input  logic               reg_wr,
    input  logic [31:0]        reg_wdata,
    input  logic               reg_rd,
    output logic [31:0]        reg_rdata,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic               irq_req
);
    logic [NUM_SRC-1:0] wd, status, en, pend;
    logic [31:0]        vec;
    logic [1:0]         mbits;
    logic               armed;

    assign wd = reg_wdata[NUM_SRC-1:0];

    irqc_master i_master (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr && reg_addr == A_MASTER),
        .wdata_i (reg_wdata[1:0]),
        .bits_o  (mbits),
        .armed_o (armed)
    );

    irqc_mask #(.NUM_SRC(NUM_SRC)) i_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_full_i (reg_wr && reg_addr == A_ENABLE),
        .wr_set_i  (reg_wr && reg_addr == A_SETEN),
        .wr_clr_i  (reg_wr && reg_addr == A_CLREN),
        .wdata_i   (wd),
        .en_o      (en)
    );

    irqc_capture #(.NUM_SRC(NUM_SRC), .EDGE_KIND(EDGE_KIND)) i_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (irq_src),
        .ack_we_i (reg_wr && reg_addr == A_ACK),
        .sw_we_i  (reg_wr && reg_addr == A_STATUS && !armed),
        .wdata_i  (wd),
        .status_o (status)
    );

    assign pend = status & en;

    irqc_vector #(.NUM_SRC(NUM_SRC)) i_vector (
        .pend_i (pend),
        .vec_o  (vec)
    );

    assign irq_req = (|pend) && (mbits == 2'b11);

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                A_STATUS:  reg_rdata = 32'(status);
                A_PENDING: reg_rdata = 32'(pend);
                A_ENABLE:  reg_rdata = 32'(en);
                A_VECTOR:  reg_rdata = vec;
                A_MASTER:  reg_rdata = {30'd0, mbits};
                default:   reg_rdata = '0;
            endcase
        end
    end

    AST_REQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (mbits == 2'b11) && (en != '0)); // R10
    AST_VECTOR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (vec != NO_VECTOR) |-> ((status & en) >> vec[4:0]) % 2 == 1); // R9
    AST_VECTOR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == NO_VECTOR) |-> (status & en) == '0); // R9
    AST_STATUS_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_STATUS && armed && irq_src == '0) |=>
            (status & ~$past(status)) == '0); // R12
endmodule

// File: tb/test_irqc_top.sv
module test_irqc_top;
    localparam int          N    = 8;
    localparam logic [31:0] KIND = 32'hA5A5_A5F0;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic        reg_rd = 0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_src = 0;
    logic        irq_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irqc_top #(.NUM_SRC(N), .EDGE_KIND(KIND)) i_irqc_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .irq_src(irq_src), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1;
        #1 d = reg_rdata;
        reg_rd = 0;
    endtask

    function automatic logic [31:0] low_idx(input logic [N-1:0] p);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = N - 1; k >= 0; k--) if (p[k]) r = k;
        return r;
    endfunction

    task automatic sample_req(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, {31'd0, irq_req}, {31'd0, exp});
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [N-1:0] acc;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        rd(0, d); check("R1 status", d, 0);
        rd(2, d); check("R1 enable", d, 0);
        rd(7, d); check("R1 master", d, 0);
        rd(6, d); check("R1 vector", d, 32'hFFFF_FFFF);
        sample_req("R1 irq_req", 0);

        // R4 / R13 full enable write
        wr(2, 32'hFFFF_FFFF); rd(2, d); check("R13 enable upper", d, 32'hFF);
        wr(2, 32'h0000_0036); rd(2, d); check("R4 enable", d, 32'h36);
        wr(2, 0);

        // R2 / R3 per-bit sweep of the aliases
        acc = 0;
        for (int i = 0; i < N; i++) begin
            wr(4, 32'h100 | (32'h1 << i)); acc[i] = 1'b1;
            rd(2, d); check("R2 set-enable", d, 32'(acc));
        end
        for (int i = 0; i < N; i++) begin
            wr(5, 32'h1 << i); acc[i] = 1'b0;
            rd(2, d); check("R3 clear-enable", d, 32'(acc));
        end

        // R12 / R8 / R9 exhaustive status patterns while unarmed
        for (int p = 0; p < 256; p++) begin
            logic [N-1:0] e;
            e = N'(p) ^ 8'h3C;
            wr(3, 32'hFFFF_FFFF);
            wr(0, 32'hFF00 | p[31:0]);
            wr(2, 32'(e));
            rd(0, d); check("R12 status write", d, 32'(p));
            rd(1, d); check("R8 pending", d, 32'(N'(p) & e));
            rd(6, d); check("R9 vector", d, low_idx(N'(p) & e));
        end

        // R5 partial and full acknowledge
        wr(3, 32'hFFFF_FFFF); wr(0, 32'hA6);
        wr(3, 32'h22); rd(0, d); check("R5 partial ack", d, 32'h84);
        wr(3, 32'hFFFF_FFFF); rd(0, d); check("R5 full ack", d, 0);

        // R14 capture with master off, then R10
        wr(2, 32'hFF);
        @(negedge clk) irq_src[5] = 1;
        @(negedge clk) irq_src[5] = 0;
        rd(0, d); check("R14 capture with master off", d, 32'h20);
        rd(6, d); check("R14 vector with master off", d, 5);
        sample_req("R10 req off", 0);
        wr(7, 1); sample_req("R10 enable only", 0);
        wr(7, 2); sample_req("R10 arm only", 0);
        wr(7, 3); rd(7, d); check("R10 master readback", d, 3);
        sample_req("R10 req live", 1);
        wr(3, 32'h20); sample_req("R10 req after ack", 0);

        // R12 locked after arm, R11 sticky arm
        wr(0, 32'hFF); rd(0, d); check("R12 status write ignored", d, 0);
        wr(7, 0); rd(7, d); check("R11 arm sticky", d, 2);
        wr(7, 1); rd(7, d); check("R11 enable back", d, 3);

        // R6 edge lines 4..7
        for (int i = 4; i < N; i++) begin
            wr(3, 32'hFF);
            @(negedge clk) irq_src[i] = 1;
            repeat (3) @(negedge clk);
            rd(0, d); check("R6 edge set", d, 32'h1 << i);
            wr(3, 32'h1 << i);
            repeat (2) @(negedge clk);
            rd(0, d); check("R6 edge held after ack", d, 0);
            @(negedge clk) irq_src[i] = 0;
        end

        // R7 level lines 0..3
        for (int i = 0; i < 4; i++) begin
            wr(3, 32'hFF);
            @(negedge clk) irq_src[i] = 1;
            @(negedge clk);
            rd(0, d); check("R7 level set", d, 32'h1 << i);
            wr(3, 32'h1 << i);
            rd(0, d); check("R7 level ack while high", d, 32'h1 << i);
            sample_req("R7 req while high", 1);
            @(negedge clk) irq_src[i] = 0;
            wr(3, 32'h1 << i);
            rd(0, d); check("R7 level cleared", d, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule